// File: doc/BRIEF.md
# External Interrupt Edge and Flag Unit

This block sits next to a small 8-bit processor core and turns asynchronous peripheral event lines into pending interrupt flags for seven external vectors. Every raw line is brought into the core clock domain, compared with its previous sample, and a qualifying edge sets the flag of its vector. Some vectors merge several events. Some lines are inverted so that their falling edges count. The edge of two vectors can be chosen by software.

Flags for vectors 0 to 5 clear themselves when the core acknowledges entry into the matching service routine. The flag of vector 6 stays set until software writes a 0 to it. The same unit holds the two timer overflow flags, which clear on their own acknowledge pulses. Software sees two 8-bit special-function registers. The edge-select register holds the polarity bits for vectors 2 and 3. The request register exposes the flags of vectors 2 to 6.

Top module: `ext_irq_unit`

## Requirements
- R1: While reset is held and after it is released, `irq_pend`, `tmr_flag`, `pol_rdata` and `flag_rdata` are all zero.
- R2: A write through `pol_wr` stores `sfr_wdata[6]` as the edge select of vector 3 and `sfr_wdata[5]` as the edge select of vector 2. `pol_rdata` returns these two bits in the same positions, and bits 7 and 4..0 always read 0.
- R3: `flag_rdata` bit 5 is the flag of vector 6, bit 4 is vector 5, bit 3 is vector 4, bit 2 is vector 3 and bit 1 is vector 2. Bits 7, 6 and 0 read 0.
- R4: Vector 2 (`meas_pulse`) and vector 3 (`meas_busy`) set their flags on a falling edge when their select bit is 0, and on a rising edge when it is 1. The opposite edge does nothing.
- R5: Vector 4 sets its flag whenever any bit of `supply_state` changes. Holding the same value sets nothing.
- R6: Vector 5 sets on a falling edge of `nvm_busy` or on a rising edge of `serial_evt`. The opposite edges do nothing.
- R7: Vector 6 sets on a falling edge of `xfer_busy`, or on a rising edge of `rtc_sec`, `rtc_min` or `rtc_alarm`.
- R8: Vectors 0 and 1 set their flags on a falling edge of `ext_pin[0]` and `ext_pin[1]` respectively.
- R9: A one-cycle pulse on `vec_ack[i]` clears flag i for i = 0..5. `vec_ack[6]` has no effect on flag 6.
- R10: A `flag_wr` write clears each of the flags of vectors 2..6 whose bit in `sfr_wdata` (positions as in R3) is 0. Writing 1 leaves a flag unchanged.
- R11: When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R12: A pulse on `tmr_ovf[k]` sets `tmr_flag[k]`, and a pulse on `tmr_ack[k]` clears it. Set wins when both arrive together. These lines are synchronous and have no extra delay.
- R13: A flag rises exactly SYNC_STAGES+1 (default 3) clock edges after its input changes. A held level never sets it again after it has been cleared.
- R14: Static input levels present at reset release set no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin | input | 2 | Raw lines for vectors 0 and 1 |
| meas_pulse | input | 1 | Measurement pulse for vector 2 |
| meas_busy | input | 1 | Measurement busy for vector 3 |
| supply_state | input | 3 | Supply status code for vector 4 |
| nvm_busy | input | 1 | Memory busy, falling edge to vector 5 |
| serial_evt | input | 1 | Serial event, rising edge to vector 5 |
| xfer_busy | input | 1 | Transfer busy, falling edge to vector 6 |
| rtc_sec | input | 1 | Clock one-second tick for vector 6 |
| rtc_min | input | 1 | Clock one-minute tick for vector 6 |
| rtc_alarm | input | 1 | Clock alarm for vector 6 |
| vec_ack | input | 7 | Per-vector service entry acknowledge |
| tmr_ovf | input | 2 | Timer 0/1 overflow pulses |
| tmr_ack | input | 2 | Timer 0/1 service acknowledge |
| pol_wr | input | 1 | Write strobe for the edge-select register |
| flag_wr | input | 1 | Write strobe for the request register |
| sfr_wdata | input | 8 | Register write data |
| pol_rdata | output | 8 | Edge-select register contents |
| flag_rdata | output | 8 | Request register contents |
| irq_pend | output | 7 | Pending flag per vector |
| tmr_flag | output | 2 | Timer overflow flags |

## Verification
The assertions assume that acknowledge, timer and write strobes are synchronous to `clk`. They also assume that `supply_state` changes at most once per synchronizer window, so it is never sampled in the middle of a transition. The stimulus drives every input on the falling clock edge. It holds each level for well over SYNC_STAGES+1 cycles before the next change, and it lands acknowledge pulses in exactly the cycle in which an edge reaches the flag register when it tests that a set beats a clear.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_VEC = 7;
  localparam int STAT_W  = 3;
  // raw line positions after synchronization
  localparam int IX_EXT0  = 0;
  localparam int IX_EXT1  = 1;
  localparam int IX_PULSE = 2;
  localparam int IX_BUSY  = 3;
  localparam int IX_STAT  = 4;
  localparam int IX_NVM   = IX_STAT + STAT_W;
  localparam int IX_SER   = IX_NVM + 1;
  localparam int IX_XFER  = IX_NVM + 2;
  localparam int IX_SEC   = IX_NVM + 3;
  localparam int IX_MIN   = IX_NVM + 4;
  localparam int IX_ALM   = IX_NVM + 5;
  localparam int NUM_RAW  = IX_ALM + 1;

  function automatic logic rise_of(input logic cur, input logic prv);
    return cur & ~prv;
  endfunction

  function automatic logic fall_of(input logic cur, input logic prv);
    return ~cur & prv;
  endfunction

  function automatic logic edge_pick(input logic cur, input logic prv, input logic rising);
    return rising ? rise_of(cur, prv) : fall_of(cur, prv);
  endfunction

  function automatic logic [NUM_VEC-1:0] flag_next(input logic [NUM_VEC-1:0] cur,
                                                   input logic [NUM_VEC-1:0] set,
                                                   input logic [NUM_VEC-1:0] clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv,
  output logic         armed
);
  localparam int ARM_CNT = STAGES + 1;
  localparam int CW      = $clog2(ARM_CNT + 1);

  logic [W-1:0] stg [STAGES];
  logic [CW-1:0] cnt;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else if (g == 0) stg[g] <= din;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv <= '0;
      cnt <= '0;
    end else begin
      prv <= stg[STAGES-1];
      if (cnt != CW'(ARM_CNT)) cnt <= cnt + 1'b1;
    end
  end

  assign cur   = stg[STAGES-1];
  assign armed = (cnt == CW'(ARM_CNT));

  // once armed, edge detection never goes quiet again until reset
  assert_arm_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
  import ext_irq_pkg::*;
(
  input  logic [NUM_RAW-1:0] cur,
  input  logic [NUM_RAW-1:0] prv,
  input  logic               armed,
  input  logic [1:0]         pol,   // [0] vector 2, [1] vector 3; 1 = rising
  output logic [NUM_VEC-1:0] evt
);
  logic [NUM_VEC-1:0] raw_evt;
  logic nvm_inv_c, nvm_inv_p, xfer_inv_c, xfer_inv_p;

  // busy lines inverted so their falling edge becomes a rising one
  assign nvm_inv_c  = ~cur[IX_NVM];
  assign nvm_inv_p  = ~prv[IX_NVM];
  assign xfer_inv_c = ~cur[IX_XFER];
  assign xfer_inv_p = ~prv[IX_XFER];

  always_comb begin
    raw_evt[0] = fall_of(cur[IX_EXT0], prv[IX_EXT0]);
    raw_evt[1] = fall_of(cur[IX_EXT1], prv[IX_EXT1]);
    raw_evt[2] = edge_pick(cur[IX_PULSE], prv[IX_PULSE], pol[0]);
    raw_evt[3] = edge_pick(cur[IX_BUSY], prv[IX_BUSY], pol[1]);
    raw_evt[4] = |(cur[IX_STAT +: STAT_W] ^ prv[IX_STAT +: STAT_W]);
    raw_evt[5] = rise_of(nvm_inv_c, nvm_inv_p) | rise_of(cur[IX_SER], prv[IX_SER]);
    raw_evt[6] = rise_of(xfer_inv_c, xfer_inv_p) | rise_of(cur[IX_SEC], prv[IX_SEC])
               | rise_of(cur[IX_MIN], prv[IX_MIN]) | rise_of(cur[IX_ALM], prv[IX_ALM]);
  end

  assign evt = armed ? raw_evt : '0;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import ext_irq_pkg::*;
#(
  parameter int N = NUM_VEC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] nxt;

  always_comb begin
    logic [NUM_VEC-1:0] wide;
    wide = flag_next(NUM_VEC'(flags), NUM_VEC'(set), NUM_VEC'(clr));
    nxt  = wide[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  // a set always lands, even against a clear
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));
  // a lone clear empties the flag
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set) != '0) |=> ((flags & $past(clr & ~set)) == '0));
  // flags never rise without a set
  assert_no_spurious_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(set)) == '0));
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ext_pin,
  input  logic              meas_pulse,
  input  logic              meas_busy,
  input  logic [STAT_W-1:0] supply_state,
  input  logic              nvm_busy,
  input  logic              serial_evt,
  input  logic              xfer_busy,
  input  logic              rtc_sec,
  input  logic              rtc_min,
  input  logic              rtc_alarm,
  input  logic [NUM_VEC-1:0] vec_ack,
  input  logic [1:0]        tmr_ovf,
  input  logic [1:0]        tmr_ack,
  input  logic              pol_wr,
  input  logic              flag_wr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        pol_rdata,
  output logic [7:0]        flag_rdata,
  output logic [NUM_VEC-1:0] irq_pend,
  output logic [1:0]        tmr_flag
);
  localparam int POL_LO  = 5;   // register bit of vector 2 select
  localparam int FLAG_LO = 1;   // register bit of vector 2 flag
  localparam int SW_LO   = 2;   // first vector clearable by software

  logic [NUM_RAW-1:0] raw_in, s_cur, s_prv;
  logic               armed;
  logic [1:0]         pol_q;
  logic [NUM_VEC-1:0] evt, clr;
  logic               unused_wbits;

  assign raw_in = {rtc_alarm, rtc_min, rtc_sec, xfer_busy, serial_evt, nvm_busy,
                   supply_state, meas_busy, meas_pulse, ext_pin[1], ext_pin[0]};

  irq_sync #(.W(NUM_RAW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in), .cur(s_cur), .prv(s_prv), .armed(armed));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (pol_wr) pol_q <= sfr_wdata[POL_LO +: 2];
  end

  irq_edge_detect u_edge (
    .cur(s_cur), .prv(s_prv), .armed(armed), .pol(pol_q), .evt(evt));

  genvar v;
  generate
    for (v = 0; v < NUM_VEC; v++) begin : g_clr
      if (v < SW_LO) begin : g_hw
        assign clr[v] = vec_ack[v];
      end else if (v < NUM_VEC-1) begin : g_both
        assign clr[v] = vec_ack[v] | (flag_wr & ~sfr_wdata[v - SW_LO + FLAG_LO]);
      end else begin : g_sw
        assign clr[v] = flag_wr & ~sfr_wdata[v - SW_LO + FLAG_LO];
      end
    end
  endgenerate

  irq_flag_bank #(.N(NUM_VEC)) u_ext_flags (
    .clk(clk), .rst_n(rst_n), .set(evt), .clr(clr), .flags(irq_pend));

  irq_flag_bank #(.N(2)) u_tmr_flags (
    .clk(clk), .rst_n(rst_n), .set(tmr_ovf), .clr(tmr_ack), .flags(tmr_flag));

  always_comb begin
    pol_rdata = '0;
    pol_rdata[POL_LO +: 2] = pol_q;
    flag_rdata = '0;
    flag_rdata[FLAG_LO +: (NUM_VEC - SW_LO)] = irq_pend[NUM_VEC-1:SW_LO];
  end

  assign unused_wbits = ^{sfr_wdata[7], sfr_wdata[0], sfr_wdata[4:1] & {4{pol_wr & 1'b0}}};

  // the last vector survives anything but a software zero
  assert_sticky_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend[NUM_VEC-1] && !(flag_wr && !sfr_wdata[NUM_VEC-1-SW_LO+FLAG_LO]))
      |=> irq_pend[NUM_VEC-1]);
  // the acknowledge of the last vector alone leaves it pending
  assert_ack_last_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack[NUM_VEC-1] && irq_pend[NUM_VEC-1] && !flag_wr) |=> irq_pend[NUM_VEC-1]);
  // the edge-select register changes only on its strobe
  assert_pol_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_wr |=> $stable(pol_rdata));
endmodule

// File: tb/sim_ext_irq_unit.sv
`timescale 1ns/1ps
module sim_ext_irq_unit;
  logic clk = 0, rst_n = 0;
  logic [1:0] ext_pin = 2'b11;
  logic meas_pulse = 0, meas_busy = 0;
  logic [2:0] supply_state = 3'b000;
  logic nvm_busy = 1, serial_evt = 0, xfer_busy = 1;
  logic rtc_sec = 0, rtc_min = 0, rtc_alarm = 0;
  logic [6:0] vec_ack = 0;
  logic [1:0] tmr_ovf = 0, tmr_ack = 0;
  logic pol_wr = 0, flag_wr = 0;
  logic [7:0] sfr_wdata = 0;
  logic [7:0] pol_rdata, flag_rdata;
  logic [6:0] irq_pend;
  logic [1:0] tmr_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_unit u0 (.*);

  task automatic step(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ack(logic [6:0] m); vec_ack = m; step(1); vec_ack = 0; endtask
  task automatic wr_flag(logic [7:0] d); sfr_wdata = d; flag_wr = 1; step(1); flag_wr = 0; endtask
  task automatic wr_pol(logic [7:0] d); sfr_wdata = d; pol_wr = 1; step(1); pol_wr = 0; endtask
  task automatic clear_all; ack(7'h7F); wr_flag(8'h00); step(1); endtask

  task automatic t_reset;
    step(2);
    chk("R1 pend in reset", irq_pend, 0);
    rst_n = 1;
    step(10);
    chk("R1 pend", irq_pend, 0);
    chk("R1 tmr", tmr_flag, 0);
    chk("R1 pol", pol_rdata, 0);
    chk("R14 flag reg", flag_rdata, 0);
  endtask

  task automatic t_pol;
    wr_pol(8'hFF); chk("R2 all ones", pol_rdata, 8'h60);
    wr_pol(8'h20); chk("R2 bit5", pol_rdata, 8'h20);
    wr_pol(8'h00); chk("R2 clear", pol_rdata, 8'h00);
  endtask

  task automatic t_vec23;
    meas_pulse = 1; step(5); chk("R4 rise ignored falling mode", irq_pend[2], 0);
    meas_pulse = 0; step(2); chk("R13 not early", irq_pend[2], 0);
    step(1); chk("R13 latency", irq_pend[2], 1);
    chk("R3 reg position v2", flag_rdata, 8'h02);
    ack(7'h04); chk("R9 ack v2", irq_pend[2], 0);
    step(5); chk("R13 no reset from level", irq_pend[2], 0);
    wr_pol(8'h20);
    meas_pulse = 1; step(3); chk("R4 rising mode v2", irq_pend[2], 1);
    ack(7'h04);
    meas_pulse = 0; step(4); chk("R4 fall ignored rising mode", irq_pend[2], 0);
    wr_pol(8'h40);
    meas_busy = 1; step(3); chk("R4 rising mode v3", irq_pend[3], 1);
    chk("R3 reg position v3", flag_rdata, 8'h04);
    ack(7'h08);
    wr_pol(8'h00);
    meas_busy = 0; step(3); chk("R4 falling mode v3", irq_pend[3], 1);
    clear_all;
  endtask

  task automatic t_vec4;
    supply_state = 3'b101; step(3); chk("R5 change", irq_pend[4], 1);
    chk("R3 reg position v4", flag_rdata, 8'h08);
    ack(7'h10);
    supply_state = 3'b101; step(5); chk("R5 same value", irq_pend[4], 0);
    supply_state = 3'b100; step(3); chk("R5 single bit", irq_pend[4], 1);
    clear_all;
  endtask

  task automatic t_vec5;
    nvm_busy = 0; step(3); chk("R6 busy fall", irq_pend[5], 1);
    chk("R3 reg position v5", flag_rdata, 8'h10);
    ack(7'h20);
    nvm_busy = 1; step(4); chk("R6 busy rise ignored", irq_pend[5], 0);
    serial_evt = 1; step(3); chk("R6 serial rise", irq_pend[5], 1);
    ack(7'h20);
    serial_evt = 0; step(4); chk("R6 serial fall ignored", irq_pend[5], 0);
    clear_all;
  endtask

  task automatic t_vec6;
    xfer_busy = 0; step(3); chk("R7 xfer fall", irq_pend[6], 1);
    chk("R3 reg position v6", flag_rdata, 8'h20);
    ack(7'h40); chk("R9 ack v6 ignored", irq_pend[6], 1);
    wr_flag(8'hFF); chk("R10 write one no effect", irq_pend[6], 1);
    wr_flag(8'hDF); chk("R10 write zero clears", irq_pend[6], 0);
    xfer_busy = 1; step(4); chk("R7 xfer rise ignored", irq_pend[6], 0);
    rtc_sec = 1; step(3); chk("R7 sec", irq_pend[6], 1);
    wr_flag(8'h00);
    rtc_min = 1; step(3); chk("R7 min", irq_pend[6], 1);
    wr_flag(8'h00);
    rtc_alarm = 1; step(3); chk("R7 alarm", irq_pend[6], 1);
    wr_flag(8'h00);
    rtc_sec = 0; rtc_min = 0; rtc_alarm = 0; step(4);
    chk("R7 tick falls ignored", irq_pend[6], 0);
  endtask

  task automatic t_vec01;
    ext_pin = 2'b10; step(3); chk("R8 v0 fall", irq_pend[1:0], 2'b01);
    ext_pin = 2'b00; step(3); chk("R8 v1 fall", irq_pend[1:0], 2'b11);
    ack(7'h01); chk("R9 ack v0", irq_pend[1:0], 2'b10);
    ack(7'h02); chk("R9 ack v1", irq_pend[1:0], 2'b00);
    ext_pin = 2'b11; step(4); chk("R8 rise ignored", irq_pend[1:0], 2'b00);
  endtask

  task automatic t_sw;
    meas_pulse = 1; meas_busy = 1; step(5);
    meas_pulse = 0; meas_busy = 0; step(3);
    chk("R10 setup", irq_pend[3:2], 2'b11);
    wr_flag(8'hFD); chk("R10 selective clear", irq_pend[3:2], 2'b10);
    clear_all;
  endtask

  task automatic t_setwins;
    meas_pulse = 1; step(5);
    meas_pulse = 0; step(2);
    vec_ack = 7'h04; step(1); vec_ack = 0;
    chk("R11 set beats ack", irq_pend[2], 1);
    ack(7'h04);
    meas_pulse = 1; step(5);
    meas_pulse = 0; step(2);
    sfr_wdata = 8'h00; flag_wr = 1; step(1); flag_wr = 0;
    chk("R11 set beats write", irq_pend[2], 1);
    clear_all;
  endtask

  task automatic t_timer;
    tmr_ovf = 2'b01; step(1); tmr_ovf = 0; chk("R12 set t0", tmr_flag, 2'b01);
    tmr_ovf = 2'b10; step(1); tmr_ovf = 0; chk("R12 set t1", tmr_flag, 2'b11);
    tmr_ack = 2'b01; step(1); tmr_ack = 0; chk("R12 ack t0", tmr_flag, 2'b10);
    tmr_ack = 2'b10; tmr_ovf = 2'b11; step(1); tmr_ack = 0; tmr_ovf = 0;
    chk("R12 set wins", tmr_flag, 2'b11);
  endtask

  initial begin
    t_reset; t_pol; t_vec23; t_vec4; t_vec5; t_vec6; t_vec01; t_sw; t_setwins; t_timer;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #600000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule